// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers event pulses from a number of peripheral groups and folds each group into a single level-sensitive interrupt line. Each group has two registers. The flag register latches every event of the group. The enable register decides which latched flags may drive that group's line. A flag is latched whether or not its enable bit is set. If a flag is enabled after it was latched, the line rises at that point. Software clears a flag by writing 1 to its bit.

A further register holds one bit per group. That bit records that an enabled event arrived while the group's line was already high. Software clears it by writing 1. All registers are reached through a plain address / write-data / write-strobe port. Read data is registered.

Top module: `evt_fold`

## Requirements
- R1: After synchronous reset every flag, enable and missed bit is zero and every `irq_o` bit is low.
- R2: A write to address NGRP+g loads the enable register of group g from `wdata_i`. A 1 bit enables that flag and a 0 bit disables it. The register reads back at the same address.
- R3: An event on `evt_i` bit g*FW+b sets flag bit b of group g (read at address g) on the next clock edge, whatever the enable bit.
- R4: A write to address g clears each flag bit where `wdata_i` holds 1. Bits where `wdata_i` holds 0 are left unchanged.
- R5: If an event and a write-1 clear hit the same flag bit in the same cycle, the flag stays set.
- R6: `irq_o[g]` is high while any flag bit of group g has its enable bit set. It stays high until every enabled flag of that group is cleared.
- R7: A flag latched while disabled drives `irq_o[g]` high once its enable bit is written to 1.
- R8: Bit g of the missed register (address 2*NGRP) is set when an enabled event of group g arrives while `irq_o[g]` is already high. A masked event does not set it. Writing 1 to the bit clears it.
- R9: `rdata_o` shows, one clock after the address is presented, the register at that address, zero-extended. An address above 2*NGRP reads zero and a write to it changes nothing. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NGRP*FW | Event pulses, group g in bits g*FW+FW-1 down to g*FW |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | DW | Registered read data |
| irq_o | output | NGRP | One level interrupt per group |

## Verification
An incoming event and a software write-1 clear can land on the same flag bit in one cycle. The bench provokes this by latching a flag, then driving its event pulse together with a clear write of that bit. Reading the flag back afterwards must show it still set. A second pairing is checked as well: a fresh enabled event arriving while the group line is already high must set the missed bit, and a masked event in the same situation must not.

// File: rtl/evt_fold_pkg.sv
package evt_fold_pkg;
  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MISS = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/evt_fold_dec.sv
module evt_fold_dec
  import evt_fold_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int AW   = 4,
  parameter int GW   = 2
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  output sel_e            sel,
  output logic [GW-1:0]   grp,
  output logic [NGRP-1:0] wr_flag,
  output logic [NGRP-1:0] wr_mask,
  output logic            wr_miss
);
  int unsigned a;

  always_comb begin
    a   = int'(addr);
    sel = SEL_NONE;
    grp = '0;
    if (a < NGRP) begin
      sel = SEL_FLAG;
      grp = GW'(a);
    end else if (a < 2 * NGRP) begin
      sel = SEL_MASK;
      grp = GW'(a - NGRP);
    end else if (a == 2 * NGRP) begin
      sel = SEL_MISS;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_strobe
    assign wr_flag[g] = wr && (sel == SEL_FLAG) && (int'(grp) == g);
    assign wr_mask[g] = wr && (sel == SEL_MASK) && (int'(grp) == g);
  end
  assign wr_miss = wr && (sel == SEL_MISS);
endmodule

// File: rtl/evt_fold_grp.sv
module evt_fold_grp #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] evt,
  input  logic          wr_flag,
  input  logic          wr_mask,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flag_o,
  output logic [FW-1:0] mask_o,
  output logic          irq_o,
  output logic          miss_set_o
);
  logic [FW-1:0] flag_q, mask_q, clr;

  assign clr = wr_flag ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | evt;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign irq_o      = |(flag_q & mask_q);
  assign miss_set_o = irq_o && |(evt & mask_q);
  assign flag_o     = flag_q;
  assign mask_o     = mask_q;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (flag_q == '0 && mask_q == '0));

  assert_event_latches_R3: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  assert_no_silent_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && |(evt & wdata)) |=> ((flag_q & $past(evt & wdata)) == $past(evt & wdata)));

  assert_level_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !wr_flag && !wr_mask) |=> irq_o);
endmodule

// File: rtl/evt_fold.sv
module evt_fold
  import evt_fold_pkg::*;
#(
  parameter int NGRP = 4,
  parameter int FW   = 8,
  localparam int NREG = 2 * NGRP + 1,
  localparam int AW   = $clog2(NREG),
  localparam int DW   = (FW > NGRP) ? FW : NGRP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NGRP*FW-1:0] evt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               wr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NGRP-1:0]    irq_o
);
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

  sel_e            sel;
  logic [GW-1:0]   grp;
  logic [NGRP-1:0] wr_flag, wr_mask, miss_set;
  logic            wr_miss;
  logic [FW-1:0]   flag_arr [NGRP];
  logic [FW-1:0]   mask_arr [NGRP];
  logic [NGRP-1:0] miss_q;
  logic [DW-1:0]   rd_mux;

  evt_fold_dec #(.NGRP(NGRP), .AW(AW), .GW(GW)) u_dec (
    .addr    (addr_i),
    .wr      (wr_i),
    .sel     (sel),
    .grp     (grp),
    .wr_flag (wr_flag),
    .wr_mask (wr_mask),
    .wr_miss (wr_miss)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    evt_fold_grp #(.FW(FW)) u_grp (
      .clk        (clk),
      .rst        (rst),
      .evt        (evt_i[g*FW +: FW]),
      .wr_flag    (wr_flag[g]),
      .wr_mask    (wr_mask[g]),
      .wdata      (wdata_i[FW-1:0]),
      .flag_o     (flag_arr[g]),
      .mask_o     (mask_arr[g]),
      .irq_o      (irq_o[g]),
      .miss_set_o (miss_set[g])
    );

    assert_missed_sets_R8: assert property (@(posedge clk) disable iff (rst)
      miss_set[g] |=> miss_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) miss_q <= '0;
    else     miss_q <= (miss_q & ~(wr_miss ? wdata_i[NGRP-1:0] : '0)) | miss_set;
  end

  always_comb begin
    case (sel)
      SEL_FLAG: rd_mux = DW'(flag_arr[grp]);
      SEL_MASK: rd_mux = DW'(mask_arr[grp]);
      SEL_MISS: rd_mux = DW'(miss_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assert_idle_irq_R1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && miss_q == '0));

  assert_miss_kept_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_miss |=> ((miss_q & $past(miss_q)) == $past(miss_q)));
endmodule

// File: tb/evt_fold_bench.sv
`timescale 1ns/1ps
module evt_fold_bench;
  localparam int NGRP = 4;
  localparam int FW   = 8;
  localparam int AW   = 4;
  localparam int DW   = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NGRP*FW-1:0] evt = '0;
  logic [AW-1:0]      addr = '0;
  logic [DW-1:0]      wdata = '0;
  logic               wr = 1'b0;
  logic [DW-1:0]      rdata;
  logic [NGRP-1:0]    irq;

  always #2 clk = ~clk;

  evt_fold #(.NGRP(NGRP), .FW(FW)) u_evt_fold (
    .clk(clk), .rst(rst), .evt_i(evt), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [DW-1:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic op(input logic [NGRP*FW-1:0] e, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input logic w);
    @(negedge clk);
    evt = e; addr = a; wdata = d; wr = w;
  endtask

  task automatic expect_rd(input logic [AW-1:0] a, input logic [DW-1:0] x, input string t);
    item_t it;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0; addr = a;
    it.is_irq = 1'b0; it.exp = x; it.tag = t;
    q.push_back(it);
  endtask

  task automatic expect_irq(input logic [NGRP-1:0] x, input string t);
    item_t it;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    it.is_irq = 1'b1; it.exp = DW'(x); it.tag = t;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [DW-1:0] got;
        it  = q.pop_front();
        got = it.is_irq ? DW'(irq) : rdata;
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a <= 2 * NGRP; a++) expect_rd(AW'(a), '0, "R1 reset register");
    expect_irq('0, "R1 reset irq");

    op(32'h1 << 3, 0, 0, 0);
    expect_rd(0, 8'h08, "R3 flag set while masked");
    expect_irq('0, "R3 masked flag keeps irq low");

    op(0, 4, 8'h08, 1);
    expect_rd(4, 8'h08, "R2 enable readback");
    expect_irq(4'b0001, "R7 late enable raises irq");

    op(0, 0, 8'h00, 1);
    expect_rd(0, 8'h08, "R4 write 0 leaves flag");
    op(0, 0, 8'h08, 1);
    expect_rd(0, 8'h00, "R4 write 1 clears flag");
    expect_irq('0, "R6 irq drops after clear");

    op(0, 5, 8'h05, 1);
    op(32'h05 << 8, 0, 0, 0);
    expect_irq(4'b0010, "R6 two enabled flags");
    op(0, 1, 8'h01, 1);
    expect_irq(4'b0010, "R6 one enabled flag left");
    expect_rd(1, 8'h04, "R4 selective clear");
    op(0, 1, 8'h04, 1);
    expect_irq('0, "R6 all cleared");

    op(32'h02 << 16, 0, 0, 0);
    expect_rd(2, 8'h02, "R3 group2 flag");
    op(32'h02 << 16, 2, 8'h02, 1);
    expect_rd(2, 8'h02, "R5 event beats clear");
    op(0, 2, 8'h02, 1);
    expect_rd(2, 8'h00, "R4 group2 clear");

    op(0, 7, 8'h01, 1);
    op(32'h01 << 24, 0, 0, 0);
    expect_rd(8, 8'h00, "R8 first event no miss");
    expect_irq(4'b1000, "R6 group3 irq");
    op(32'h02 << 24, 0, 0, 0);
    expect_rd(8, 8'h00, "R8 masked event no miss");
    op(32'h01 << 24, 0, 0, 0);
    expect_rd(8, 8'h08, "R8 miss set");
    op(0, 8, 8'h08, 1);
    expect_rd(8, 8'h00, "R8 miss cleared");

    expect_rd(15, 8'h00, "R9 out of range reads zero");
    op(0, 15, 8'hFF, 1);
    expect_rd(4, 8'h08, "R9 out of range write ignored");
    expect_rd(3, 8'h03, "R9 read once");
    expect_rd(3, 8'h03, "R9 read twice no side effect");

    op(0, 4, 8'h00, 1);
    op(32'h1 << 3, 0, 0, 0);
    expect_irq(4'b1000, "R2 disabled bit keeps group0 low");
    expect_rd(0, 8'h08, "R3 flag latched while disabled");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule